// File: doc/BRIEF.md
# Iterative 320-bit Permutation Core

This block keeps a 320-bit state as five 64-bit words and applies one full round of the permutation on every clock cycle. A round first folds a one-byte round constant into the low byte of word 2. It then runs the bit-sliced 5-bit substitution layer, which is built from XOR pre-mixing, a chi-style nonlinear core, XOR post-mixing and the inversion of one word. It ends with the linear diffusion layer, where each word is XORed with two right-rotated copies of itself.

A one-cycle `start` pulse while the core is idle loads the five input words. The core then runs twelve rounds back to back. It pulses `done` and presents the five result words in parallel on registered outputs. These outputs hold their value until the next permutation completes. A `start` that arrives while the core is busy is dropped.

Top module: `perm320_core`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are 0 and all five result words are zero.
- R2: `start` sampled high on a rising edge while `busy` is 0 loads the input words, and `busy` reads 1 after that edge.
- R3: `done` is high for exactly one cycle, after the 12th edge following the accepting edge. `busy` is 0 from that same edge on.
- R4: Round k (k = 0..11) XORs the constant {4'hF - k, k} into bits 7:0 of word 2 before anything else. The sequence runs 0xF0, 0xE1, ... 0x4B.
- R5: Substitution layer: w0 ^= w4, w4 ^= w3, w2 ^= w1. Then t[i] = w[i] ^ (~w[(i+1) mod 5] & w[(i+2) mod 5]). Then t1 ^= t0, t0 ^= t4, t3 ^= t2, t2 = ~t2.
- R6: Diffusion replaces each word with itself XOR two right-rotations of itself. The rotation pairs are: word 0 by 19 and 28, word 1 by 61 and 39, word 2 by 1 and 6, word 3 by 10 and 17, word 4 by 7 and 41.
- R7: `start` is ignored while `busy` is 1. Neither the result nor the timing of `done` changes, and no extra `done` follows.
- R8: The result words change only on the edge that raises `done`, and they are stable at all other times.
- R9: A `start` sampled on the edge right after the one that raised `done` is accepted, so runs can follow each other without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load the inputs and run the permutation |
| in_w0 | input | 64 | State word 0 to load |
| in_w1 | input | 64 | State word 1 to load |
| in_w2 | input | 64 | State word 2 to load |
| in_w3 | input | 64 | State word 3 to load |
| in_w4 | input | 64 | State word 4 to load |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| out_w0 | output | 64 | Result word 0 |
| out_w1 | output | 64 | Result word 1 |
| out_w2 | output | 64 | Result word 2 |
| out_w3 | output | 64 | Result word 3 |
| out_w4 | output | 64 | Result word 4 |

## Verification
The hardest situations to reach from the ports are the two edges of the busy window: a `start` held high across a running permutation, and a new `start` on the first cycle after `done`. The stimulus holds `start` high for several cycles while it changes the input words. It also watches `done` and raises `start` in that same cycle for the next run. A queue of model results, each stamped with its due cycle, catches both a wrong result and a late, early or repeated `done`.

// File: rtl/perm320_pkg.sv
package perm320_pkg;
  localparam int WORD_W  = 64;
  localparam int N_WORDS = 5;
  localparam int RC_W    = 8;

  typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

  function automatic int rot_first(input int idx);
    case (idx)
      0:       return 19;
      1:       return 61;
      2:       return 1;
      3:       return 10;
      default: return 7;
    endcase
  endfunction

  function automatic int rot_second(input int idx);
    case (idx)
      0:       return 28;
      1:       return 39;
      2:       return 6;
      3:       return 17;
      default: return 41;
    endcase
  endfunction
endpackage

// File: rtl/perm320_rcgen.sv
module perm320_rcgen #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0]          idx,
  output logic [perm320_pkg::RC_W-1:0] rc
);
  logic [3:0] lo;
  assign lo = 4'(idx);
  // high nibble counts down from F as low nibble counts up from 0
  assign rc = {4'hF - lo, lo};
endmodule

// File: rtl/perm320_round.sv
module perm320_round
  import perm320_pkg::*;
(
  input  state_t          st_in,
  input  logic [RC_W-1:0] rc,
  output state_t          st_out
);
  state_t pre;
  state_t chi;
  state_t post;

  always_comb begin
    pre    = st_in;
    pre[2] = pre[2] ^ {{(WORD_W-RC_W){1'b0}}, rc};
    pre[0] = pre[0] ^ pre[4];
    pre[4] = pre[4] ^ pre[3];
    pre[2] = pre[2] ^ pre[1];
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_chi
    assign chi[g] = pre[g] ^ (~pre[(g+1)%N_WORDS] & pre[(g+2)%N_WORDS]);
  end

  always_comb begin
    post    = chi;
    post[1] = chi[1] ^ chi[0];
    post[0] = chi[0] ^ chi[4];
    post[3] = chi[3] ^ chi[2];
    post[2] = ~chi[2];
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_diff
    localparam int RA = rot_first(g);
    localparam int RB = rot_second(g);
    assign st_out[g] = post[g]
                     ^ ((post[g] >> RA) | (post[g] << (WORD_W - RA)))
                     ^ ((post[g] >> RB) | (post[g] << (WORD_W - RB)));
  end
endmodule

// File: rtl/perm320_ctrl.sv
module perm320_ctrl #(
  parameter int ROUNDS = 12,
  parameter int CNT_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load,
  output logic             last,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROUNDS - 1);

  assign load = start & ~busy;
  assign last = busy & (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done && cnt == '0));

  // R7
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST_IDX) |=> (busy && !done));

  // R3
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST_IDX) |=> (done && !busy));

  // R3
  done_origin_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
endmodule

// File: rtl/perm320_core.sv
module perm320_core #(
  parameter int ROUNDS = 12,
  parameter int CNT_W  = $clog2(ROUNDS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [63:0] in_w0,
  input  logic [63:0] in_w1,
  input  logic [63:0] in_w2,
  input  logic [63:0] in_w3,
  input  logic [63:0] in_w4,
  output logic        busy,
  output logic        done,
  output logic [63:0] out_w0,
  output logic [63:0] out_w1,
  output logic [63:0] out_w2,
  output logic [63:0] out_w3,
  output logic [63:0] out_w4
);
  import perm320_pkg::*;

  logic             load;
  logic             last;
  logic [CNT_W-1:0] cnt;
  logic [RC_W-1:0]  rc;
  state_t           state_q;
  state_t           result_q;
  state_t           next_st;

  perm320_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .last(last),
    .busy(busy), .done(done), .cnt(cnt)
  );

  perm320_rcgen #(.CNT_W(CNT_W)) u_rc (.idx(cnt), .rc(rc));

  perm320_round u_round (.st_in(state_q), .rc(rc), .st_out(next_st));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= '0;
      result_q <= '0;
    end else if (load) begin
      state_q <= {in_w4, in_w3, in_w2, in_w1, in_w0};
    end else if (busy) begin
      state_q <= next_st;
      if (last) result_q <= next_st;
    end
  end

  assign out_w0 = result_q[0];
  assign out_w1 = result_q[1];
  assign out_w2 = result_q[2];
  assign out_w3 = result_q[3];
  assign out_w4 = result_q[4];

  // R8
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (done || $stable({out_w4, out_w3, out_w2, out_w1, out_w0})));

  // R3
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/perm320_core_tb.sv
module perm320_core_tb;
  typedef logic [4:0][63:0] st_t;
  typedef struct { st_t val; int due; } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] in_w [5];
  logic        busy, done;
  logic [63:0] out_w0, out_w1, out_w2, out_w3, out_w4;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  exp_t sb[$];
  st_t  last_res;
  bit   have_res = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial for (int i = 0; i < 5; i++) in_w[i] = '0;

  perm320_core u_dut (
    .clk(clk), .rst(rst), .start(start),
    .in_w0(in_w[0]), .in_w1(in_w[1]), .in_w2(in_w[2]), .in_w3(in_w[3]), .in_w4(in_w[4]),
    .busy(busy), .done(done),
    .out_w0(out_w0), .out_w1(out_w1), .out_w2(out_w2), .out_w3(out_w3), .out_w4(out_w4)
  );

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic st_t model(input st_t s);
    logic [63:0] x [5];
    logic [63:0] t [5];
    for (int i = 0; i < 5; i++) x[i] = s[i];
    for (int r = 0; r < 12; r++) begin
      x[2] ^= {56'd0, 4'(15 - r), 4'(r)};
      x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
      for (int i = 0; i < 5; i++) t[i] = x[i] ^ (~x[(i+1)%5] & x[(i+2)%5]);
      t[1] ^= t[0]; t[0] ^= t[4]; t[3] ^= t[2]; t[2] = ~t[2];
      x[0] = t[0] ^ rr(t[0], 19) ^ rr(t[0], 28);
      x[1] = t[1] ^ rr(t[1], 61) ^ rr(t[1], 39);
      x[2] = t[2] ^ rr(t[2], 1)  ^ rr(t[2], 6);
      x[3] = t[3] ^ rr(t[3], 10) ^ rr(t[3], 17);
      x[4] = t[4] ^ rr(t[4], 7)  ^ rr(t[4], 41);
    end
    return {x[4], x[3], x[2], x[1], x[0]};
  endfunction

  function automatic st_t outs();
    return {out_w4, out_w3, out_w2, out_w1, out_w0};
  endfunction

  task automatic set_in(input st_t v);
    for (int i = 0; i < 5; i++) in_w[i] = v[i];
  endtask

  // driver: called at a negedge; start is sampled at the following posedge
  task automatic launch(input st_t v, input int hold);
    exp_t e;
    set_in(v);
    start = 1'b1;
    e.val = model(v);
    e.due = cyc + 13;
    sb.push_back(e);
    @(negedge clk);
    checks++;
    if (busy !== 1'b1) begin
      errors++;
      $display("FAIL R2 busy after accept: actual %b expected 1", busy);
    end
    for (int k = 1; k < hold; k++) begin
      set_in(v ^ {5{64'hA5A5_0000_0000_0000 + 64'(k)}});
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done === 1'b1) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R3/R7 unexpected done at cycle %0d, expected none", cyc);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (outs() !== e.val) begin
            errors++;
            $display("FAIL R4 R5 R6 result: actual %h expected %h", outs(), e.val);
          end
          checks++;
          if (cyc != e.due || busy !== 1'b0) begin
            errors++;
            $display("FAIL R3 done timing: actual cycle %0d busy %b expected cycle %0d busy 0",
                     cyc, busy, e.due);
          end
          last_res = e.val;
          have_res = 1'b1;
        end
      end else if (have_res) begin
        checks++;
        if (outs() !== last_res) begin
          errors++;
          $display("FAIL R8 outputs moved: actual %h expected %h", outs(), last_res);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    st_t v;
    logic [63:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || outs() !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual busy %b done %b out %h expected 0 0 0", busy, done, outs());
    end

    // zero state
    launch('0, 1);
    wait_done();
    @(negedge clk);

    // counting pattern, then idle with moving inputs (R8)
    for (int i = 0; i < 5; i++) v[i] = 64'h0001_0203_0405_0607 + 64'(i) * 64'h0808_0808_0808_0808;
    launch(v, 1);
    wait_done();
    for (int k = 0; k < 6; k++) begin
      set_in(v ^ {5{64'(k * 977)}});
      @(negedge clk);
    end

    // R7 start held high while busy with changing inputs
    launch({5{64'hFFFF_FFFF_FFFF_FFFF}}, 7);
    wait_done();
    repeat (3) @(negedge clk);

    // R9 back-to-back: new start in the cycle done is visible
    launch({64'h4, 64'h3, 64'h2, 64'h1, 64'h0}, 1);
    wait_done();
    launch({64'hDEAD_BEEF_0000_0001, 64'h0, 64'h8000_0000_0000_0000, 64'h1, 64'hFF}, 1);
    wait_done();
    @(negedge clk);

    // pseudo-random vectors
    lf = 64'hC0FF_EE12_3456_789B;
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 5; i++) begin
        lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]} ^ (lf >> 7);
        v[i] = lf;
      end
      launch(v, 1);
      wait_done();
      @(negedge clk);
    end

    repeat (20) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R3 missing done: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule